// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block saves the interrupted program counter, and optionally the extended status byte, onto a byte-wide stack when an interrupt is taken. It restores them when the handler returns. It drives a single-port stack memory with one byte per clock and owns the 16-bit stack pointer. Its results are a restored 24-bit PC, a restored status byte, a one-cycle done pulse and, on returns, a one-cycle pulse that releases the serviced priority level to the interrupt controller.

A static frame-size input chooses between two frame sizes. The short frame holds the low 16 PC bits, and a return from it lands in the top 64 KB region. The long frame holds the status byte and the full 24-bit PC. The block latches the frame size when it accepts a strobe. Instruction decode, vector selection and priority arbitration are outside this block.

Top module: `irq_ctx_seq`

## Requirements
- R1: With `frame_long_i`=0, an entry writes exactly two bytes: pc[7:0] first, then pc[15:8].
- R2: With `frame_long_i`=0, a return reads two bytes (the byte at the top of the stack is pc[15:8], the one below it is pc[7:0]) and sets `pc_o` = {8'hFF, pc[15:8], pc[7:0]}.
- R3: With `frame_long_i`=1, an entry writes four bytes in this order: status, pc[23:16], pc[7:0], pc[15:8].
- R4: With `frame_long_i`=1, a return reads four bytes in the reverse of entry order and restores `psw_o` and all 24 bits of `pc_o`.
- R5: `prio_rel_o` pulses for one cycle together with `done_o` at the end of every return, and never at the end of an entry.
- R6: A push first increments the stack pointer and then writes at the new value. A pop reads at the current value and then decrements. `sp_o` wraps modulo 2^16.
- R7: One byte is transferred per clock, starting in the cycle after the strobe. `busy_o` is high for exactly as many cycles as there are frame bytes, and `done_o` is high for one cycle right after them.
- R8: An entry or return strobe that arrives while `busy_o` is high is ignored. The transfer in progress continues unchanged and no extra frame follows.
- R9: Entry and return strobes raised together while idle start nothing. `err_o` pulses for one cycle and `sp_o` is unchanged.
- R10: `pc_o` and `psw_o` change only at the end of a return. A short-frame return leaves `psw_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_long_i | input | 1 | 1 selects the four-byte frame, 0 the two-byte frame |
| enter_i | input | 1 | Interrupt-entry strobe |
| leave_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 24 | PC to save on entry |
| psw_i | input | 8 | Status byte to save on entry |
| mem_addr_o | output | 16 | Stack memory address |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_rdata_i | input | 8 | Stack memory read data, valid in the same cycle as the address |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 24 | Restored PC |
| psw_o | output | 8 | Restored status byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prio_rel_o | output | 1 | One-cycle priority-release pulse on return |
| err_o | output | 1 | One-cycle pulse on simultaneous strobes |

## Verification
Consider a strobe sampled at clock edge E0. Byte k of the frame appears on the memory port in the cycle after edge E0+k. `done_o`, `prio_rel_o`, `pc_o`, `psw_o` and the final `sp_o` are due in the cycle after edge E0+n, where n is the frame length, and `err_o` is due in the cycle after E0. The bench drives strobes on falling edges and samples the memory port once per cycle at the falling edge of each transfer cycle. It then samples the completion outputs at the next falling edge, so every check lands in the exact cycle its result is due. Every sweep starts the stack pointer two below the wrap point, so pushes and pops cross 16'hFFFF/16'h0000.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int PC_W   = 24;
  localparam int LANES  = 4;
  localparam int IDX_W  = 2;

  // lane numbering of the shared frame buffer
  localparam logic [1:0] F_PC_LO  = 2'd0;
  localparam logic [1:0] F_PC_MID = 2'd1;
  localparam logic [1:0] F_PC_HI  = 2'd2;
  localparam logic [1:0] F_PSW    = 2'd3;

  typedef enum logic {OP_PUSH = 1'b0, OP_POP = 1'b1} op_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} st_e;

  function automatic logic [IDX_W-1:0] frame_last(input logic long_f);
    return long_f ? 2'd3 : 2'd1;
  endfunction

  // stack slot (push order) -> frame lane
  function automatic logic [1:0] slot_field(input logic long_f, input logic [IDX_W-1:0] slot);
    logic [1:0] f;
    if (long_f) begin
      case (slot)
        2'd0:    f = F_PSW;
        2'd1:    f = F_PC_HI;
        2'd2:    f = F_PC_LO;
        default: f = F_PC_MID;
      endcase
    end else begin
      f = slot[0] ? F_PC_MID : F_PC_LO;
    end
    return f;
  endfunction
endpackage

// File: rtl/irq_ctx_sp.sv
module irq_ctx_sp #(
  parameter int              SP_W   = 16,
  parameter logic [SP_W-1:0] SP_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] addr_o
);
  logic [SP_W-1:0] sp_q, sp_inc, sp_dec;

  assign sp_inc = sp_q + SP_W'(1);
  assign sp_dec = sp_q - SP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_RST;
    else if (inc_i) sp_q <= sp_inc;
    else if (dec_i) sp_q <= sp_dec;
  end

  // pre-increment for push, current for pop
  assign addr_o = inc_i ? sp_inc : sp_q;
  assign sp_o   = sp_q;
endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_long_i,
  input  logic             enter_i,
  input  logic             leave_i,
  output logic             cap_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             long_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             commit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             prio_o,
  output logic             err_o
);
  st_e             st_q;
  op_e             op_q;
  logic            long_q;
  logic [IDX_W-1:0] idx_q;
  logic            done_q, prio_q, err_q;
  logic            start_push, start_pop, clash, last;

  assign clash      = (st_q == ST_IDLE) && enter_i && leave_i;
  assign start_push = (st_q == ST_IDLE) && enter_i && !leave_i;
  assign start_pop  = (st_q == ST_IDLE) && leave_i && !enter_i;
  assign last       = idx_q == frame_last(long_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PUSH;
      long_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
      prio_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      prio_q <= 1'b0;
      err_q  <= clash;
      if (st_q == ST_IDLE) begin
        if (start_push || start_pop) begin
          st_q   <= ST_XFER;
          op_q   <= start_pop ? OP_POP : OP_PUSH;
          long_q <= frame_long_i;
          idx_q  <= '0;
        end
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        if (last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          prio_q <= op_q == OP_POP;
        end
      end
    end
  end

  assign cap_o    = start_push;
  assign push_o   = (st_q == ST_XFER) && (op_q == OP_PUSH);
  assign pop_o    = (st_q == ST_XFER) && (op_q == OP_POP);
  assign commit_o = pop_o && last;
  assign long_o   = long_q;
  assign idx_o    = idx_q;
  assign busy_o   = st_q == ST_XFER;
  assign done_o   = done_q;
  assign prio_o   = prio_q;
  assign err_o    = err_q;
endmodule

// File: rtl/irq_ctx_frame.sv
module irq_ctx_frame
  import irq_ctx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [7:0]       psw_i,
  input  logic             long_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             pop_i,
  input  logic             commit_i,
  input  logic [7:0]       rdata_i,
  output logic [7:0]       wdata_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [7:0]       psw_o
);
  logic [7:0] lane_q   [LANES];
  logic [7:0] lane_nxt [LANES];
  logic [1:0] push_fld, pop_fld;

  assign push_fld = slot_field(long_i, idx_i);
  assign pop_fld  = slot_field(long_i, frame_last(long_i) - idx_i);

  // one buffer serves as push source and pop assembly
  always_comb begin
    for (int i = 0; i < LANES; i++) lane_nxt[i] = lane_q[i];
    if (cap_i) begin
      lane_nxt[F_PC_LO]  = pc_i[7:0];
      lane_nxt[F_PC_MID] = pc_i[15:8];
      lane_nxt[F_PC_HI]  = pc_i[23:16];
      lane_nxt[F_PSW]    = psw_i;
    end else if (pop_i) begin
      lane_nxt[pop_fld] = rdata_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q[g] <= '0;
      else         lane_q[g] <= lane_nxt[g];
    end
  end

  assign wdata_o = lane_q[push_fld];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o  <= '0;
      psw_o <= '0;
    end else if (commit_i) begin
      pc_o <= {long_i ? lane_nxt[F_PC_HI] : 8'hFF, lane_nxt[F_PC_MID], lane_nxt[F_PC_LO]};
      if (long_i) psw_o <= lane_nxt[F_PSW];
    end
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int              SP_W   = 16,
  parameter logic [SP_W-1:0] SP_RST = SP_W'(7)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_long_i,
  input  logic            enter_i,
  input  logic            leave_i,
  input  logic [23:0]     pc_i,
  input  logic [7:0]      psw_i,
  output logic [SP_W-1:0] mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic            mem_we_o,
  input  logic [7:0]      mem_rdata_i,
  output logic [SP_W-1:0] sp_o,
  output logic [23:0]     pc_o,
  output logic [7:0]      psw_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            prio_rel_o,
  output logic            err_o
);
  logic             cap, push, pop, long_f, commit;
  logic [IDX_W-1:0] idx;

  irq_ctx_ctrl i_ctrl (
    .clk_i, .rst_ni, .frame_long_i, .enter_i, .leave_i,
    .cap_o(cap), .push_o(push), .pop_o(pop), .long_o(long_f), .idx_o(idx),
    .commit_o(commit), .busy_o, .done_o, .prio_o(prio_rel_o), .err_o
  );

  irq_ctx_sp #(.SP_W(SP_W), .SP_RST(SP_RST)) i_sp (
    .clk_i, .rst_ni, .inc_i(push), .dec_i(pop), .sp_o, .addr_o(mem_addr_o)
  );

  irq_ctx_frame i_frame (
    .clk_i, .rst_ni, .cap_i(cap), .pc_i, .psw_i, .long_i(long_f), .idx_i(idx),
    .pop_i(pop), .commit_i(commit), .rdata_i(mem_rdata_i),
    .wdata_o(mem_wdata_o), .pc_o, .psw_o
  );

  assign mem_we_o = push;
endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk #(
  parameter int SP_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_long_i,
  input logic            mem_we_o,
  input logic [SP_W-1:0] mem_addr_o,
  input logic [SP_W-1:0] sp_o,
  input logic [23:0]     pc_o,
  input logic [7:0]      psw_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            prio_rel_o,
  input logic            err_o
);
  AST_WE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R7
  AST_PUSH_PREINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == sp_o + SP_W'(1)); // R6
  AST_PUSH_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(sp_o) + SP_W'(1)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_PRIO_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_rel_o |-> done_o); // R5
  AST_SHORT_TOP_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_rel_o && !frame_long_i) |-> pc_o[23:16] == 8'hFF); // R2
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !mem_we_o); // R9
  AST_SP_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(sp_o)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(pc_o) && $stable(psw_o)); // R10
endmodule

bind irq_ctx_seq irq_ctx_chk #(.SP_W(SP_W)) i_irq_ctx_chk (
  .clk_i, .rst_ni, .frame_long_i, .mem_we_o, .mem_addr_o, .sp_o, .pc_o, .psw_o,
  .busy_o, .done_o, .prio_rel_o, .err_o
);

// File: tb/test_irq_ctx_seq.sv
module test_irq_ctx_seq;
  localparam logic [15:0] SP0 = 16'hFFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_long = 1'b0, enter = 1'b0, leave = 1'b0;
  logic [23:0] pc_in = '0;
  logic [7:0]  psw_in = '0;
  logic [15:0] mem_addr, sp;
  logic [7:0]  mem_wdata, mem_rdata, psw_out;
  logic        mem_we, busy, done, prio_rel, err;
  logic [23:0] pc_out;
  logic [7:0]  mem [256];
  int          checks = 0, fails = 0;
  logic [23:0] exp_pc;
  logic [7:0]  exp_psw;

  always #10 clk = ~clk;

  irq_ctx_seq #(.SP_W(16), .SP_RST(SP0)) i_irq_ctx_seq (
    .clk_i(clk), .rst_ni(rst_n), .frame_long_i(frame_long), .enter_i(enter), .leave_i(leave),
    .pc_i(pc_in), .psw_i(psw_in), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .sp_o(sp), .pc_o(pc_out), .psw_o(psw_out),
    .busy_o(busy), .done_o(done), .prio_rel_o(prio_rel), .err_o(err)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] push_byte(input logic lng, input int k,
                                           input logic [23:0] p, input logic [7:0] s);
    if (lng) begin
      case (k)
        0: return s;
        1: return p[23:16];
        2: return p[7:0];
        default: return p[15:8];
      endcase
    end
    return (k == 0) ? p[7:0] : p[15:8];
  endfunction

  task automatic do_enter(input logic lng, input logic [23:0] p, input logic [7:0] s,
                          input logic poke);
    int n;
    logic [15:0] sp_start;
    logic [23:0] pc_keep;
    logic [7:0]  psw_keep;
    n = lng ? 4 : 2;
    @(negedge clk);
    frame_long = lng; pc_in = p; psw_in = s; enter = 1'b1;
    sp_start = sp; pc_keep = pc_out; psw_keep = psw_out;
    @(negedge clk);
    enter = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (poke) leave = (k == 1); // R8 strobe during busy
      chk(lng ? "R3 push data" : "R1 push data", {24'd0, mem_wdata}, {24'd0, push_byte(lng, k, p, s)});
      chk("R6 push addr", {16'd0, mem_addr}, {16'd0, sp_start + 16'(k + 1)});
      chk("R7 busy/we", {30'd0, busy, mem_we}, 32'd3);
      if (k < n - 1) @(negedge clk);
    end
    leave = 1'b0;
    @(negedge clk);
    chk("R7 done after entry", {30'd0, done, busy}, 32'd2);
    chk("R5 no release on entry", {31'd0, prio_rel}, 32'd0);
    chk("R6 sp after push", {16'd0, sp}, {16'd0, sp_start + 16'(n)});
    chk("R10 pc held on entry", {8'd0, pc_out}, {8'd0, pc_keep});
    chk("R10 psw held on entry", {24'd0, psw_out}, {24'd0, psw_keep});
    if (poke) begin
      @(negedge clk);
      chk("R8 no extra frame", {30'd0, busy, mem_we}, 32'd0);
      chk("R8 sp unchanged", {16'd0, sp}, {16'd0, sp_start + 16'(n)});
    end
  endtask

  task automatic do_leave(input logic lng, input logic [23:0] p, input logic [7:0] s);
    int n;
    logic [15:0] sp_start;
    n = lng ? 4 : 2;
    @(negedge clk);
    frame_long = lng; leave = 1'b1; sp_start = sp;
    exp_pc = lng ? p : {8'hFF, p[15:0]};
    exp_psw = lng ? s : psw_out;
    @(negedge clk);
    leave = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk("R6 pop addr", {16'd0, mem_addr}, {16'd0, sp_start - 16'(k)});
      chk("R7 busy no we", {30'd0, busy, mem_we}, 32'd2);
      if (k < n - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R7 done after return", {30'd0, done, busy}, 32'd2);
    chk("R5 release on return", {31'd0, prio_rel}, 32'd1);
    chk(lng ? "R4 pc restore" : "R2 pc restore", {8'd0, pc_out}, {8'd0, exp_pc});
    chk(lng ? "R4 psw restore" : "R10 psw kept", {24'd0, psw_out}, {24'd0, exp_psw});
    chk("R6 sp after pop", {16'd0, sp}, {16'd0, sp_start - 16'(n)});
    @(negedge clk);
    chk("R5 release one cycle", {30'd0, done, prio_rel}, 32'd0);
  endtask

  initial begin
    logic [23:0] pa, pb;
    logic [7:0]  sa;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 reset idle", {29'd0, busy, done, mem_we}, 32'd0);
    chk("R6 reset sp", {16'd0, sp}, {16'd0, SP0});
    chk("R10 reset results", {psw_out, pc_out}, 32'd0);
    rst_n = 1'b1;
    // sweep: both modes over several patterns, all wrapping the stack pointer
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 6; v++) begin
        pa = 24'h5A3C96 ^ (24'h111111 * 24'(v)) ^ {12'(v), 12'(v * 7)};
        sa = 8'hC3 ^ 8'(v * 37);
        do_enter(m[0], pa, sa, 1'b0);
        do_leave(m[0], pa, sa);
      end
    end
    // nested frames, mixed modes
    pa = 24'hABCDEF; pb = 24'h012345;
    do_enter(1'b1, pa, 8'h5E, 1'b0);
    do_enter(1'b0, pb, 8'h77, 1'b0);
    do_leave(1'b0, pb, 8'h77);
    do_leave(1'b1, pa, 8'h5E);
    // strobe while busy
    do_enter(1'b1, 24'h13579B, 8'h24, 1'b1);
    do_leave(1'b1, 24'h13579B, 8'h24);
    // simultaneous strobes R9
    @(negedge clk);
    enter = 1'b1; leave = 1'b1;
    @(negedge clk);
    enter = 1'b0; leave = 1'b0;
    chk("R9 err pulse", {29'd0, err, busy, mem_we}, 32'd4);
    chk("R9 sp unchanged", {16'd0, sp}, {16'd0, SP0});
    @(negedge clk);
    chk("R9 err one cycle", {29'd0, err, busy, done}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule